// File: doc/BRIEF.md
# Strobe-Handshake Byte Queue Port

This block connects an external device to local logic through a byte-wide parallel port that runs with no clock of its own. There are two queues. Local logic fills a receive queue, and the external device empties it with read strobes. The external device fills a transmit queue with write strobes, and local logic empties it. Two active-low handshake outputs tell the external device when it may act. `rxf_n` low means a byte is waiting to be read. `txe_n` low means a byte may be written.

The external read and write strobes have no timing relation to the system clock. Each one passes through a synchroniser and an edge detector in the system clock domain. Write data is sampled through a synchroniser of the same depth, so it lines up with the write strobe. The port drives the data bus only while the read strobe is low. The driven value is the oldest unread byte. That byte is removed when the strobe returns high. Each handshake flag goes inactive for every strobe cycle and becomes active again only from the registered queue state.

Top module: `strobe_byte_port`

## Requirements
- R1: After reset the outputs are as follows: `rxf_n`=1, `txe_n`=0, `wr_overrun_err`=0, `ext_data_oe`=0, `rx_push_ready`=1 and `tx_pop_valid`=0.
- R2: `ext_data_oe` is 1 exactly while `ext_rd_n` is 0. While it is 1, `ext_data_out` carries the oldest unread receive byte.
- R3: A read cycle consists of `ext_rd_n` going low and then high. It removes exactly one byte, once the rising edge has been synchronised. The next read then presents the next byte, and bytes come out in the order they were pushed.
- R4: No more than 3 clocks after `ext_rd_n` falls, `rxf_n` is 1, and it stays 1 while `ext_rd_n` is low. At least one clock after the byte has been removed, `rxf_n` returns to 0 if a byte is still queued. `rxf_n` is 1 whenever the receive queue is empty.
- R5: When `ext_wr_n` goes from 1 to 0, the byte on `ext_data_in` is written into the transmit queue. The byte must be held steady for 3 clocks after the fall. Bytes reach `tx_pop_data` in the order they were written.
- R6: No more than 3 clocks after `ext_wr_n` falls, `txe_n` is 1. It stays 1 until `ext_wr_n` has returned high and the transmit queue has a free entry. `txe_n` is 1 while the transmit queue holds TX_DEPTH (16) bytes.
- R7: A write strobe that falls while `txe_n` is 1 queues no byte. It sets `wr_overrun_err`, which stays 1 until reset.
- R8: `rx_push_ready` is 0 while the receive queue holds RX_DEPTH (16) bytes. A push offered at that time is dropped.
- R9: `tx_pop_valid` is 1 while the transmit queue is not empty. A clock edge with `tx_pop_ready` high removes the byte shown on `tx_pop_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_push_valid | input | 1 | Local side offers a byte for the receive queue |
| rx_push_data | input | DATA_W | Byte offered to the receive queue |
| rx_push_ready | output | 1 | Receive queue has room |
| tx_pop_ready | input | 1 | Local side takes the head byte of the transmit queue |
| tx_pop_data | output | DATA_W | Head byte of the transmit queue |
| tx_pop_valid | output | 1 | Transmit queue is not empty |
| ext_rd_n | input | 1 | External read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | External write strobe, active low, asynchronous |
| ext_data_in | input | DATA_W | Data bus value seen at the pads |
| ext_data_out | output | DATA_W | Value driven onto the data bus |
| ext_data_oe | output | 1 | Data bus output enable |
| rxf_n | output | 1 | Byte available to read, active low |
| txe_n | output | 1 | Space available to write, active low |
| wr_overrun_err | output | 1 | Sticky flag: a write strobe arrived while `txe_n` was high |

## Verification
The case hardest to reach from the ports is a write strobe that the port must refuse. This needs the transmit queue completely full and the external side still writing. The stimulus writes sixteen distinct bytes, one per handshake, with no local pops, and then sends a seventeenth strobe carrying a marker byte. Draining the queue afterwards shows whether the marker slipped in. Long alternating push/read and write/pop runs wrap both queue pointers several times, with every byte value computed from its index.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int unsigned SPF_DATA_W      = 8;
  localparam int unsigned SPF_DEPTH       = 16;
  localparam int unsigned SPF_SYNC_STAGES = 2;

  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_evt_t;
endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spf_strobe_edge.sv
module spf_strobe_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_n,
  output spf_pkg::strobe_evt_t evt
);
  logic lvl;
  logic prev_q;

  spf_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_n),
    .q    (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  always_comb begin
    evt.fall = prev_q & ~lvl;
    evt.rise = ~prev_q & lvl;
  end
endmodule

// File: rtl/spf_queue.sv
module spf_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  // R8: occupancy never passes the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a lone removal lowers occupancy by exactly one
  assert_pop_drops_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9: a removal request on an empty queue changes nothing
  assert_empty_pop_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(rptr_q) && empty));
endmodule

// File: rtl/strobe_byte_port.sv
module strobe_byte_port #(
  parameter int unsigned DATA_W      = spf_pkg::SPF_DATA_W,
  parameter int unsigned RX_DEPTH    = spf_pkg::SPF_DEPTH,
  parameter int unsigned TX_DEPTH    = spf_pkg::SPF_DEPTH,
  parameter int unsigned SYNC_STAGES = spf_pkg::SPF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_push_valid,
  input  logic [DATA_W-1:0] rx_push_data,
  output logic              rx_push_ready,
  input  logic              tx_pop_ready,
  output logic [DATA_W-1:0] tx_pop_data,
  output logic              tx_pop_valid,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic [DATA_W-1:0] ext_data_in,
  output logic [DATA_W-1:0] ext_data_out,
  output logic              ext_data_oe,
  output logic              rxf_n,
  output logic              txe_n,
  output logic              wr_overrun_err
);
  import spf_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // strobe synchronisation and edge detection
  strobe_evt_t rd_evt, wr_evt;
  logic [DATA_W-1:0] wdata_s;

  spf_strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk(clk), .rst_n(rst_n_i), .pin_n(ext_rd_n), .evt(rd_evt)
  );
  spf_strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst_n(rst_n_i), .pin_n(ext_wr_n), .evt(wr_evt)
  );
  spf_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_wdata_sync (
    .clk(clk), .rst_n(rst_n_i), .d(ext_data_in), .q(wdata_s)
  );

  // handshake state
  logic rd_busy_q, rd_busy_d;
  logic wr_busy_q, wr_busy_d;
  logic rxf_n_q, rxf_n_d;
  logic txe_n_q, txe_n_d;
  logic err_q, err_d;
  logic rx_pop, tx_push;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic [DATA_W-1:0] rx_head;

  assign rx_pop  = rd_evt.rise & rd_busy_q;
  assign tx_push = wr_evt.fall & ~txe_n_q;

  always_comb begin
    rd_busy_d = rd_busy_q;
    if (rd_evt.fall) rd_busy_d = 1'b1;
    if (rd_evt.rise) rd_busy_d = 1'b0;

    wr_busy_d = wr_busy_q;
    if (wr_evt.fall) wr_busy_d = 1'b1;
    if (wr_evt.rise) wr_busy_d = 1'b0;

    rxf_n_d = rd_busy_q | rd_evt.fall | rd_evt.rise | rx_empty;
    txe_n_d = wr_busy_q | wr_evt.fall | wr_evt.rise | tx_full;
    err_d   = err_q | (wr_evt.fall & txe_n_q);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_busy_q <= 1'b0;
      wr_busy_q <= 1'b0;
      rxf_n_q   <= 1'b1;
      txe_n_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      rd_busy_q <= rd_busy_d;
      wr_busy_q <= wr_busy_d;
      rxf_n_q   <= rxf_n_d;
      txe_n_q   <= txe_n_d;
      err_q     <= err_d;
    end
  end

  // queues
  spf_queue #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_i),
    .push(rx_push_valid), .push_data(rx_push_data),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spf_queue #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_i),
    .push(tx_push), .push_data(wdata_s),
    .pop(tx_pop_ready), .head(tx_pop_data), .full(tx_full), .empty(tx_empty)
  );

  // outputs
  assign rx_push_ready  = ~rx_full;
  assign tx_pop_valid   = ~tx_empty;
  assign ext_data_oe    = ~ext_rd_n;
  assign ext_data_out   = rx_head;
  assign rxf_n          = rxf_n_q;
  assign txe_n          = txe_n_q;
  assign wr_overrun_err = err_q;

  // R4: flag stays idle for the whole read cycle
  assert_rxf_idle_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_busy_q |-> rxf_n_q);
  // R4: flag never claims data from an empty queue
  assert_rxf_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_empty |-> rxf_n_q);
  // R6: flag stays idle for the whole write cycle
  assert_txe_idle_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_busy_q |-> txe_n_q);
  // R6: flag never offers space in a full queue
  assert_txe_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_full |-> txe_n_q);
  // R7: overrun flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    err_q |=> err_q);
  // R7: a refused write leaves the transmit queue unchanged
  assert_refused_write_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_evt.fall && txe_n_q && !tx_pop_ready) |=> $stable(tx_pop_data));
endmodule

// File: tb/sim_strobe_byte_port.sv
module sim_strobe_byte_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_push_valid, tx_pop_ready, ext_rd_n, ext_wr_n;
  logic [7:0] rx_push_data, ext_data_in;
  logic [7:0] tx_pop_data, ext_data_out;
  logic       rx_push_ready, tx_pop_valid, ext_data_oe, rxf_n, txe_n, wr_overrun_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  strobe_byte_port u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data), .rx_push_ready(rx_push_ready),
    .tx_pop_ready(tx_pop_ready), .tx_pop_data(tx_pop_data), .tx_pop_valid(tx_pop_valid),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_data_in(ext_data_in),
    .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .rxf_n(rxf_n), .txe_n(txe_n), .wr_overrun_err(wr_overrun_err)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 53 + 7) & 255);
  endfunction

  task automatic local_push(input logic [7:0] b);
    rx_push_valid = 1'b1; rx_push_data = b;
    cyc(1);
    rx_push_valid = 1'b0;
  endtask

  task automatic ext_read(input logic [7:0] exp, input bit more);
    ext_rd_n = 1'b0;
    cyc(1);
    chk("R2 oe while read", ext_data_oe, 1);
    chk("R3 read byte", ext_data_out, exp);
    cyc(3);
    chk("R4 rxf idle during read", rxf_n, 1);
    ext_rd_n = 1'b1;
    cyc(1);
    chk("R2 oe off after read", ext_data_oe, 0);
    cyc(5);
    chk("R4 rxf after read", rxf_n, more ? 0 : 1);
  endtask

  task automatic ext_write(input logic [7:0] b);
    ext_data_in = b;
    cyc(1);
    ext_wr_n = 1'b0;
    cyc(4);
    chk("R6 txe idle during write", txe_n, 1);
    ext_wr_n = 1'b1;
    cyc(5);
  endtask

  task automatic local_pop(input logic [7:0] exp);
    chk("R9 pop valid", tx_pop_valid, 1);
    chk("R5 written byte", tx_pop_data, exp);
    tx_pop_ready = 1'b1;
    cyc(1);
    tx_pop_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_push_valid = 1'b0; rx_push_data = '0; tx_pop_ready = 1'b0;
    ext_rd_n = 1'b1; ext_wr_n = 1'b1; ext_data_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 rxf_n", rxf_n, 1);
    chk("R1 txe_n", txe_n, 0);
    chk("R1 err", wr_overrun_err, 0);
    chk("R1 oe", ext_data_oe, 0);
    chk("R1 push_ready", rx_push_ready, 1);
    chk("R1 pop_valid", tx_pop_valid, 0);

    // fill receive queue (R8), then drain externally (R3, R4)
    for (int i = 0; i < 16; i++) local_push(rx_pat(i));
    chk("R8 ready low when full", rx_push_ready, 0);
    local_push(8'hAA);
    cyc(3);
    chk("R4 rxf active with data", rxf_n, 0);
    for (int i = 0; i < 16; i++) ext_read(rx_pat(i), i < 15);
    chk("R8 dropped push absent", rxf_n, 1);
    chk("R8 ready after drain", rx_push_ready, 1);

    // fill transmit queue (R5, R6), then overrun (R7)
    for (int i = 0; i < 16; i++) begin
      chk("R6 txe active with space", txe_n, 0);
      ext_write(tx_pat(i));
    end
    chk("R6 txe idle when full", txe_n, 1);
    chk("R7 no error on legal writes", wr_overrun_err, 0);
    ext_write(8'hEE);
    chk("R7 overrun flagged", wr_overrun_err, 1);
    for (int i = 0; i < 16; i++) local_pop(tx_pat(i));
    chk("R7 refused byte not queued", tx_pop_valid, 0);
    chk("R7 error sticky", wr_overrun_err, 1);
    cyc(2);
    chk("R6 txe active after drain", txe_n, 0);

    // pointer-wrap sweeps on both queues
    for (int i = 0; i < 40; i++) begin
      local_push(rx_pat(i + 100));
      cyc(3);
      chk("R4 rxf active single byte", rxf_n, 0);
      ext_read(rx_pat(i + 100), 1'b0);
    end
    for (int i = 0; i < 40; i++) begin
      chk("R6 txe ready sweep", txe_n, 0);
      ext_write(tx_pat(i + 200));
      local_pop(tx_pat(i + 200));
      chk("R9 empty after pop", tx_pop_valid, 0);
      cyc(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule